// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decoder

This block is the arithmetic and logic unit of a single-cycle integer datapath, together with the small decoder that picks its operation. The main instruction decoder upstream gives it only a coarse 2-bit operation class. Memory-access instructions need an address sum and branches need an equality compare, so those classes force add or subtract directly. Only the register-to-register class looks at the 6-bit function field to choose among add, subtract, AND, OR and signed set-on-less-than.

The whole path is combinational. The decoder turns the class and function field into a 4-bit operation code, which also appears on a port for observation. From that code it builds a small bundle of strobes that steers the datapath: invert the second operand, carry-in, overflow enable and result select. The datapath returns the result word, a zero flag for branch decisions, and a signed overflow flag.

Top module: `alu_top`

## Requirements
- R1: Operation class 00 (memory access) yields operation code 0010 (add), whatever the function field holds.
- R2: Operation class 01 (branch) yields operation code 0110 (subtract), whatever the function field holds.
- R3: With class 10 (register), function 100000 gives code 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001 and 101010 gives 0111.
- R4: Class 11, or class 10 with any function value not listed in R3, yields code 0010 (add).
- R5: Code 0000 outputs the bitwise AND of the operands; code 0001 outputs the bitwise OR.
- R6: Code 0010 outputs operandA + operandB, and code 0110 outputs operandA - operandB, both modulo 2^32.
- R7: Code 0111 outputs 1 when operandA is less than operandB as signed two's-complement values and 0 otherwise. The value is in bit 0 and all higher bits are zero, even when the internal subtraction overflows.
- R8: zero is 1 exactly when every result bit is 0.
- R9: overflow is 1 when an add or subtract overflows as signed two's complement (the operands' signs agree for add, or differ for subtract, and the result's sign differs from operandA). It is always 0 for AND, OR and set-on-less-than. An unsigned carry-out alone does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 2 | Coarse operation class from the main decoder |
| funct | input | 6 | Function field of a register-class instruction |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Second operand |
| aluOp | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The checker assumes that opClass and funct always carry known values and that outputs are only judged once the inputs have been stable for a settled evaluation. The block has no state, so nothing is assumed about history. The bench changes inputs only on rising clock edges and reads outputs on falling edges, so every comparison sees settled values. It sweeps all 64 function codes under each class, including class 11 and the unlisted function codes, so the decode checks see every legal input value.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W    = 4;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FUNCT_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    RES_SUM  = 2'd0,
    RES_AND  = 2'd1,
    RES_OR   = 2'd2,
    RES_LESS = 2'd3
  } res_sel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     invertB;
    logic     carryIn;
    logic     ovfEnable;
    res_sel_e resSel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] opClass,
  input  logic [FUNCT_W-1:0] funct,
  output logic [OP_W-1:0]    aluOp,
  output alu_ctrl_t          ctrl
);

  alu_op_e functOp;
  alu_op_e selOp;

  // Second level: only consulted for the register class
  always_comb begin
    unique case (funct)
      FN_ADD:  functOp = OP_ADD;
      FN_SUB:  functOp = OP_SUB;
      FN_AND:  functOp = OP_AND;
      FN_OR:   functOp = OP_OR;
      FN_SLT:  functOp = OP_SLT;
      default: functOp = OP_ADD;
    endcase
  end

  // First level: coarse class forces add or subtract
  always_comb begin
    unique case (op_class_e'(opClass))
      CLS_MEM:    selOp = OP_ADD;
      CLS_BRANCH: selOp = OP_SUB;
      CLS_REG:    selOp = functOp;
      default:    selOp = OP_ADD;
    endcase
  end

  // Strobes derived from the operation code
  always_comb begin
    ctrl = '{invertB: 1'b0, carryIn: 1'b0, ovfEnable: 1'b0, resSel: RES_SUM};
    unique case (selOp)
      OP_AND: ctrl.resSel = RES_AND;
      OP_OR:  ctrl.resSel = RES_OR;
      OP_ADD: ctrl.ovfEnable = 1'b1;
      OP_SUB: begin
        ctrl.invertB   = 1'b1;
        ctrl.carryIn   = 1'b1;
        ctrl.ovfEnable = 1'b1;
      end
      OP_SLT: begin
        ctrl.invertB = 1'b1;
        ctrl.carryIn = 1'b1;
        ctrl.resSel  = RES_LESS;
      end
      default: ctrl.resSel = RES_SUM;
    endcase
  end

  assign aluOp = selOp;

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_ctrl_t          ctrl,
  input  logic [WIDTH-1:0]   operandA,
  input  logic [WIDTH-1:0]   operandB,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] bSel;
  logic [WIDTH-1:0] sum;
  logic             rawOvf;
  logic             lessFlag;

  assign bSel = ctrl.invertB ? ~operandB : operandB;
  assign sum  = operandA + bSel + WIDTH'(ctrl.carryIn);

  // Signed overflow of the adder: like-signed inputs, differently signed sum
  assign rawOvf   = (operandA[MSB] == bSel[MSB]) && (sum[MSB] != operandA[MSB]);
  // True signed order, corrected for overflow of the subtraction
  assign lessFlag = sum[MSB] ^ rawOvf;

  always_comb begin
    unique case (ctrl.resSel)
      RES_AND:  result = operandA & operandB;
      RES_OR:   result = operandA | operandB;
      RES_LESS: result = {{(WIDTH-1){1'b0}}, lessFlag};
      default:  result = sum;
    endcase
  end

  assign overflow = ctrl.ovfEnable & rawOvf;
  assign zero     = (result == '0);

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       opClass,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic [3:0]       aluOp,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  alu_ctrl_t ctrl;

  alu_ctrl_decode ctrl_i (
    .opClass (opClass),
    .funct   (funct),
    .aluOp   (aluOp),
    .ctrl    (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .ctrl     (ctrl),
    .operandA (operandA),
    .operandB (operandB),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

endmodule

// File: rtl/alu_top_checker.sv
module alu_top_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [1:0]       opClass,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] operandA,
  input logic [WIDTH-1:0] operandB,
  input logic [3:0]       aluOp,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow
);

  always_comb begin
    p_mem_add_r1: assert (opClass != 2'b00 || aluOp == 4'b0010)
      else $error("p_mem_add_r1 aluOp=%b", aluOp);
    p_branch_sub_r2: assert (opClass != 2'b01 || aluOp == 4'b0110)
      else $error("p_branch_sub_r2 aluOp=%b", aluOp);
    p_funct_and_r3: assert (!(opClass == 2'b10 && funct == 6'b100100) || aluOp == 4'b0000)
      else $error("p_funct_and_r3 aluOp=%b", aluOp);
    p_spare_add_r4: assert (opClass != 2'b11 || aluOp == 4'b0010)
      else $error("p_spare_add_r4 aluOp=%b", aluOp);
    p_logic_and_r5: assert (aluOp != 4'b0000 || result == (operandA & operandB))
      else $error("p_logic_and_r5 result=%h", result);
    p_sum_r6: assert (aluOp != 4'b0010 || result == operandA + operandB)
      else $error("p_sum_r6 result=%h", result);
    p_slt_upper_r7: assert (aluOp != 4'b0111 || result[WIDTH-1:1] == '0)
      else $error("p_slt_upper_r7 result=%h", result);
    p_zero_r8: assert (!zero || result == '0)
      else $error("p_zero_r8 result=%h", result);
    p_no_overflow_r9: assert (!(aluOp == 4'b0000 || aluOp == 4'b0001 || aluOp == 4'b0111) || !overflow)
      else $error("p_no_overflow_r9 aluOp=%b", aluOp);
  end

endmodule

bind alu_top alu_top_checker #(.WIDTH(WIDTH)) chk_i (
  .opClass  (opClass),
  .funct    (funct),
  .operandA (operandA),
  .operandB (operandB),
  .aluOp    (aluOp),
  .result   (result),
  .zero     (zero),
  .overflow (overflow)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;

  typedef struct packed {
    logic [1:0]  cls;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  op;
    logic [31:0] res;
    logic        z;
    logic        ov;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 6'b100100, 32'h00000005, 32'h00000007, 4'b0010, 32'h0000000C, 1'b0, 1'b0}, // R1
    '{2'b01, 6'b100000, 32'h00000009, 32'h00000009, 4'b0110, 32'h00000000, 1'b1, 1'b0}, // R2 R8
    '{2'b10, 6'b100000, 32'h7FFFFFFF, 32'h00000001, 4'b0010, 32'h80000000, 1'b0, 1'b1}, // R3 R9
    '{2'b10, 6'b100010, 32'h80000000, 32'h00000001, 4'b0110, 32'h7FFFFFFF, 1'b0, 1'b1}, // R6 R9
    '{2'b10, 6'b100100, 32'hF0F0F0F0, 32'hFF00FF00, 4'b0000, 32'hF000F000, 1'b0, 1'b0}, // R5
    '{2'b10, 6'b100101, 32'hF0F0F0F0, 32'h0F0F0F0F, 4'b0001, 32'hFFFFFFFF, 1'b0, 1'b0}, // R5
    '{2'b10, 6'b101010, 32'hFFFFFFFF, 32'h00000001, 4'b0111, 32'h00000001, 1'b0, 1'b0}, // R7
    '{2'b10, 6'b101010, 32'h00000001, 32'hFFFFFFFF, 4'b0111, 32'h00000000, 1'b1, 1'b0}, // R7
    '{2'b10, 6'b101010, 32'h80000000, 32'h7FFFFFFF, 4'b0111, 32'h00000001, 1'b0, 1'b0}, // R7 R9
    '{2'b11, 6'b100010, 32'h00000003, 32'h00000004, 4'b0010, 32'h00000007, 1'b0, 1'b0}, // R4
    '{2'b10, 6'b000000, 32'hFFFFFFFF, 32'h00000001, 4'b0010, 32'h00000000, 1'b1, 1'b0}, // R4 R9
    '{2'b10, 6'b100010, 32'h00000005, 32'h00000005, 4'b0110, 32'h00000000, 1'b1, 1'b0}, // R6 R8
    '{2'b01, 6'b111111, 32'h00000000, 32'h00000001, 4'b0110, 32'hFFFFFFFF, 1'b0, 1'b0}, // R2
    '{2'b00, 6'b101010, 32'h80000000, 32'h80000000, 4'b0010, 32'h00000000, 1'b1, 1'b1}  // R1 R9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  opClass = '0;
  logic [5:0]  funct = '0;
  logic [31:0] operandA = '0;
  logic [31:0] operandB = '0;
  logic [3:0]  aluOp;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu_top dut_i (
    .opClass  (opClass),
    .funct    (funct),
    .operandA (operandA),
    .operandB (operandB),
    .aluOp    (aluOp),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    opClass  = c;
    funct    = f;
    operandA = a;
    operandB = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: all-zero inputs give add of zeros
    drive(2'b00, 6'd0, 32'd0, 32'd0);
    check("R1", "reset aluOp", {28'd0, aluOp}, 32'h2);
    check("R8", "reset zero", {31'd0, zero}, 32'd1);
    check("R9", "reset overflow", {31'd0, overflow}, 32'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].cls, VECS[i].fn, VECS[i].a, VECS[i].b);
      check("R3", $sformatf("vec %0d aluOp", i), {28'd0, aluOp}, {28'd0, VECS[i].op});
      check("R6", $sformatf("vec %0d result", i), result, VECS[i].res);
      check("R8", $sformatf("vec %0d zero", i), {31'd0, zero}, {31'd0, VECS[i].z});
      check("R9", $sformatf("vec %0d overflow", i), {31'd0, overflow}, {31'd0, VECS[i].ov});
    end

    // Full function-field sweep under every class
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        logic [3:0] expOp;
        drive(2'(c), 6'(f), 32'h1234_5678, 32'h0F0F_0F0F);
        if (c == 1) expOp = 4'b0110;
        else if (c == 2) begin
          case (6'(f))
            6'b100000: expOp = 4'b0010;
            6'b100010: expOp = 4'b0110;
            6'b100100: expOp = 4'b0000;
            6'b100101: expOp = 4'b0001;
            6'b101010: expOp = 4'b0111;
            default:   expOp = 4'b0010;
          endcase
        end else expOp = 4'b0010;
        check(c == 0 ? "R1" : c == 1 ? "R2" : c == 2 ? "R3" : "R4",
              $sformatf("sweep c=%0d f=%0d", c, f), {28'd0, aluOp}, {28'd0, expOp});
      end
    end

    // Pseudo-random add, subtract and signed compare against a bench model
    begin
      logic [31:0] lfsr = 32'hACE1_1234;
      for (int n = 0; n < 60; n++) begin
        logic [31:0] a;
        logic [31:0] b;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a = lfsr;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        b = lfsr;
        drive(2'b00, 6'd0, a, b);
        check("R6", "random add", result, a + b);
        drive(2'b01, 6'd0, a, b);
        check("R6", "random sub", result, a - b);
        drive(2'b10, 6'b101010, a, b);
        check("R7", "random slt", result, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R9", "random slt ovf", {31'd0, overflow}, 32'd0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule